// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a serial port that sits as a slave on a memory bus with separate request and response channels. Each channel has its own valid/ready handshake. Software sends a byte by writing one register. It learns whether the transmitter is free, and whether received data is waiting, from a status register. It takes received bytes one at a time by reading a data register, and each read removes the byte it returns.

The serial side uses one start bit, eight data bits with the least significant bit first, one stop bit, and no parity. The bit period is a whole number of clock cycles set by a parameter. Received bytes wait in a small first-in first-out buffer until software reads them. The register window is decoded from the low twelve address bits only, so it can be placed at any 4 KB aligned base. An access to an offset the block does not implement gets an error response.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `tx` is high, `rsp_valid` is low, `req_ready` is high, and the status register reads 0.
- R2: `rsp_valid` rises on the clock edge after the edge that accepts a request. It stays high with `rsp_rdata` and `rsp_err` unchanged until a cycle in which `rsp_ready` is high. `req_ready` is low whenever a response is pending.
- R3: Only `req_addr[11:0]` is decoded. The mapped offsets are 0x000 (transmit), 0x004 (receive) and 0x008 (status). Any other offset gets `rsp_err`=1 and `rsp_rdata`=0 and changes no state. Mapped offsets get `rsp_err`=0.
- R4: A write to offset 0x000 while the transmitter is idle sends `req_wdata[7:0]` on `tx` as a frame: a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles, and the start bit begins right after the accepting edge.
- R5: A read of offset 0x008 returns bit 0 = transmitter busy and bit 1 = receive data waiting, with all other bits 0. Both bits reflect the state just before the accepting edge. Busy lasts 10*CLKS_PER_BIT cycles from the accepting edge.
- R6: A write to offset 0x000 while the transmitter is busy is dropped: the frame in progress on `tx` is unchanged and no second frame follows.
- R7: The receiver finds the falling edge of the start bit and samples each bit at its middle. A read of offset 0x004 returns the oldest queued byte in bits 7:0, with zeros above, and removes it from the buffer.
- R8: A read of offset 0x004 with the buffer empty returns 0 and removes nothing.
- R9: A received frame whose stop bit is low is discarded.
- R10: When FIFO_DEPTH bytes are already queued, a newly received byte is discarded and the queued bytes are kept.
- R11: Reads of offset 0x000 and writes to offsets 0x004 and 0x008 return `rsp_rdata`=0 and `rsp_err`=0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 32 | Byte address, low 12 bits decoded |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size, not used by this slave |
| req_wdata | input | 32 | Write data, byte 0 used |
| req_wstrb | input | 4 | Byte enables, not used by this slave |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped offset fault |
| tx | output | 1 | Serial transmit line, idle high |
| rx | input | 1 | Serial receive line, idle high |

## Verification
A response is due one edge after its request is accepted. A transmitted bit k is due from k*CLKS_PER_BIT cycles after the accepting edge until just before (k+1)*CLKS_PER_BIT, and the busy flag clears at 10*CLKS_PER_BIT. The bench keeps a reference on a cycle count of its own. On every falling edge it compares `tx`, `rsp_valid` and `req_ready` with the values that reference predicts. It works out each expected read value, including status and queue contents, from the state before the accepting edge. A received byte is expected in the queue only after its whole frame plus a margin has been driven on `rx`. The design takes about 9.5 bit times plus three synchronizer and edge cycles to push it.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int CLKS_PER_BIT = 868,
  parameter int FIFO_DEPTH   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_we,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_wstrb,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        tx,
  input  logic        rx
);
  localparam int CW   = $clog2(CLKS_PER_BIT) + 1;
  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic [11:0] off;
  logic        sel_tx, sel_rx, sel_st, acc, pop, push, load;
  logic        tx_busy, rx_valid, full;
  logic [31:0] rd_mux;
  logic        unused_ok;

  assign off       = req_addr[11:0];
  assign sel_tx    = off == 12'h000;
  assign sel_rx    = off == 12'h004;
  assign sel_st    = off == 12'h008;
  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign unused_ok = ^{req_addr[31:12], req_size, req_wdata[31:8], req_wstrb};

  logic [7:0]  fifo_mem [FIFO_DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   rx_count;

  assign rx_valid = rx_count != '0;
  assign full     = rx_count == (AW+1)'(FIFO_DEPTH);
  assign pop      = acc && !req_we && sel_rx && rx_valid;

  always_comb begin
    rd_mux = '0;
    if (!req_we && sel_rx && rx_valid) rd_mux = {24'b0, fifo_mem[rd_ptr]};
    else if (!req_we && sel_st)        rd_mux = {30'b0, rx_valid, tx_busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= !(sel_tx || sel_rx || sel_st);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  logic [9:0]    tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;

  assign tx      = tx_sh[0];
  assign tx_busy = tx_left != 4'd0;
  assign load    = acc && req_we && sel_tx && !tx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (load) begin
      tx_sh   <= {1'b1, req_wdata[7:0], 1'b0};
      tx_left <= 4'd10;
      tx_cnt  <= '0;
    end else if (tx_busy) begin
      if (tx_cnt == CW'(CLKS_PER_BIT - 1)) begin
        tx_cnt  <= '0;
        tx_sh   <= {1'b1, tx_sh[9:1]};
        tx_left <= tx_left - 4'd1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  logic [2:0]    rx_q;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_nbit;
  logic [7:0]    rx_sh;
  logic          rx_s, rx_last;

  assign rx_s    = rx_q[1];
  assign rx_last = rx_cnt == CW'(CLKS_PER_BIT - 1);
  assign push    = (rx_st == RX_STOP) && rx_last && rx_s && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 3'b111;
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_nbit <= '0;
      rx_sh   <= '0;
    end else begin
      rx_q <= {rx_q[1:0], rx};
      case (rx_st)
        RX_IDLE: if (rx_q[2] && !rx_s) begin
          rx_st  <= RX_START;
          rx_cnt <= '0;
        end
        RX_START: if (rx_cnt == CW'(HALF - 1)) begin
          rx_cnt  <= '0;
          rx_nbit <= '0;
          rx_st   <= rx_s ? RX_IDLE : RX_DATA;
        end else rx_cnt <= rx_cnt + 1'b1;
        RX_DATA: if (rx_last) begin
          rx_cnt <= '0;
          rx_sh  <= {rx_s, rx_sh[7:1]};
          if (rx_nbit == 3'd7) rx_st <= RX_STOP;
          else rx_nbit <= rx_nbit + 3'd1;
        end else rx_cnt <= rx_cnt + 1'b1;
        default: if (rx_last) begin
          rx_cnt <= '0;
          rx_st  <= RX_IDLE;
        end else rx_cnt <= rx_cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rx_count <= '0;
    end else begin
      if (push) begin
        fifo_mem[wr_ptr] <= rx_sh;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   rx_count <= rx_count + 1'b1;
        2'b01:   rx_count <= rx_count - 1'b1;
        default: rx_count <= rx_count;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int DEPTH = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [31:0]              req_addr,
  input logic                     req_we,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [31:0]              rsp_rdata,
  input logic                     rsp_err,
  input logic                     tx,
  input logic                     tx_busy,
  input logic [$clog2(DEPTH):0]   rx_count
);
  logic [11:0] off;
  logic        mapped, acc;
  assign off    = req_addr[11:0];
  assign mapped = off == 12'h000 || off == 12'h004 || off == 12'h008;
  assign acc    = req_valid && req_ready;

  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R2
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R3
  unmapped_err_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !mapped |=> rsp_err && rsp_rdata == 32'h0);

  // R3
  mapped_ok_chk: assert property (@(posedge clk) disable iff (rst)
    acc && mapped |=> !rsp_err);

  // R11
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    acc && req_we && (off == 12'h004 || off == 12'h008) |=> rsp_rdata == 32'h0);

  // R4
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx);

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(FIFO_DEPTH)) chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_we(req_we), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .tx(tx), .tx_busy(tx_busy), .rx_count(rx_count)
);

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
  localparam int CPB   = 8;
  localparam int DEPTH = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b0, rx = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = 2'b10;
  logic [3:0]  req_wstrb = 4'hF;
  logic        req_ready, rsp_valid, rsp_err, tx;
  logic [31:0] rsp_rdata;

  uart_mmio #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_size(req_size),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tx(tx), .rx(rx)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int cyc = 0;
  int tx_start = -1000000;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rxq[$];
  bit m_pend = 1'b0;
  logic [31:0] base = 32'hABCD_E000;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit frame_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst) m_pend = 1'b0;
    else if (m_pend) m_pend = !rsp_ready;
    else m_pend = req_valid;
  end

  always @(negedge clk) begin
    if (!rst) begin
      int el;
      bit exp_tx;
      el = cyc - tx_start;
      exp_tx = (el >= 0 && el < 10*CPB) ? frame_bit(tx_data, el / CPB) : 1'b1;
      chk(tx == exp_tx, "R4", "tx line", tx, exp_tx);
      chk(rsp_valid == m_pend, "R2", "rsp_valid", rsp_valid, m_pend);
      chk(req_ready == !m_pend, "R2", "req_ready", req_ready, !m_pend);
    end
  end

  task automatic bus(input logic [31:0] a, input bit we, input logic [31:0] wd,
                     input string req);
    logic [31:0] exp_rd;
    bit exp_err, busy;
    logic [11:0] o;
    o = a[11:0];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    busy = (cyc - 1 - tx_start) < 10*CPB;
    exp_err = !(o == 12'h000 || o == 12'h004 || o == 12'h008);
    exp_rd = 32'h0;
    if (!we && o == 12'h004 && rxq.size() > 0) exp_rd = {24'h0, rxq.pop_front()};
    if (!we && o == 12'h008) exp_rd = {30'h0, rxq.size() > 0, busy};
    if (we && o == 12'h000 && !busy) begin
      tx_start = cyc;
      tx_data = wd[7:0];
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, req, "response due", rsp_valid, 1);
    chk(rsp_rdata == exp_rd, req, "rdata", rsp_rdata, exp_rd);
    chk(rsp_err == exp_err, req, "err", rsp_err, exp_err);
    @(negedge clk);
    chk(rsp_rdata == exp_rd && rsp_err == exp_err, "R2", "held response", rsp_rdata, exp_rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit good_stop);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rx = (k == 9) ? good_stop : frame_bit(b, k);
      repeat (CPB - 1) @(negedge clk);
    end
    @(negedge clk);
    rx = 1'b1;
    repeat (2*CPB) @(negedge clk);
    if (good_stop && rxq.size() < DEPTH) rxq.push_back(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(tx == 1'b1, "R1", "tx after reset", tx, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    bus(base | 32'h8, 1'b0, 0, "R1");

    // R4 R5 R6 transmit, busy status, dropped write
    bus(base | 32'h0, 1'b1, 32'hFFFF_FFA5, "R4");
    bus(base | 32'h8, 1'b0, 0, "R5");
    bus(base | 32'h0, 1'b1, 32'h0000_003C, "R6");
    idle(12*CPB);
    bus(base | 32'h8, 1'b0, 0, "R5");

    // R3 unmapped offsets and a different base
    bus(base | 32'h00C, 1'b0, 0, "R3");
    bus(base | 32'h100, 1'b0, 0, "R3");
    bus(base | 32'hFFC, 1'b1, 32'h55, "R3");
    bus(32'h1234_5008, 1'b0, 0, "R3");
    bus(32'h1234_5010, 1'b1, 32'h99, "R3");

    // R11 ignored accesses
    bus(base | 32'h0, 1'b0, 0, "R11");
    bus(base | 32'h4, 1'b1, 32'h77, "R11");
    bus(base | 32'h8, 1'b1, 32'h3, "R11");
    bus(base | 32'h8, 1'b0, 0, "R11");

    // R8 empty read
    bus(base | 32'h4, 1'b0, 0, "R8");
    bus(base | 32'h8, 1'b0, 0, "R8");

    // R7 receive in order
    send_rx(8'h5A, 1'b1);
    send_rx(8'hC3, 1'b1);
    bus(base | 32'h8, 1'b0, 0, "R7");
    bus(base | 32'h4, 1'b0, 0, "R7");
    bus(base | 32'h4, 1'b0, 0, "R7");
    bus(base | 32'h4, 1'b0, 0, "R8");

    // R9 bad stop bit, then recovery
    send_rx(8'h77, 1'b0);
    idle(2*CPB);
    bus(base | 32'h8, 1'b0, 0, "R9");
    bus(base | 32'h4, 1'b0, 0, "R9");
    send_rx(8'h11, 1'b1);
    bus(base | 32'h4, 1'b0, 0, "R9");

    // R10 overflow
    for (int i = 0; i < DEPTH + 2; i++) send_rx(8'h80 + 8'(i*13), 1'b1);
    for (int i = 0; i < DEPTH + 1; i++) bus(base | 32'h4, 1'b0, 0, "R10");

    // R4 R7 transmit and receive together
    bus(base | 32'h0, 1'b1, 32'h01, "R4");
    send_rx(8'hE7, 1'b1);
    bus(base | 32'h8, 1'b0, 0, "R5");
    bus(base | 32'h4, 1'b0, 0, "R7");
    idle(4*CPB);
    bus(base | 32'h0, 1'b1, 32'hFF, "R4");
    idle(11*CPB);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule